// File: doc/BRIEF.md
# Two-Operand NaN Propagation Unit

This unit produces the result of a two-input single-precision floating-point operation in which at least one operand is a NaN. It sorts each operand into three classes: ordinary value, quiet NaN or signaling NaN. The quiet bit can be read with either polarity. It then picks the operand whose NaN wins under a selectable policy. If the winner is signaling, it is made quiet. In default-NaN mode the unit substitutes a fixed pattern instead. It also raises a sticky invalid-operation flag.

An arithmetic pipeline presents the two operands with a valid strobe, together with the policy code and the two mode bits. With the output register enabled (`REG_OUT`=1), the chosen word and the output valid appear on the cycle after the strobe. They then hold until the next strobe. The invalid flag stays set until the clear input is pulsed.

Top module: `nan_propagator`

## Requirements
- R1: With `sigBitOne`=0, a word is a quiet NaN when its exponent bits 30:23 are all ones and bit 22 is set. It is a signaling NaN when the exponent is all ones, bit 22 is clear and bits 21:0 are not all zero. An all-ones exponent with a zero fraction (infinity) is not a NaN.
- R2: With `sigBitOne`=1 the two tests swap. A NaN with bit 22 set is signaling, and a NaN with bit 22 clear is quiet. For example, 0x7FC00000 is signaling in this convention.
- R3: Policy code 0 picks a when a is signaling. Otherwise it picks b when b is signaling, then a when a is quiet, and b in every other case.
- R4: Policy code 1 picks a when a is any NaN, otherwise b.
- R5: Policy code 2, when exactly one operand is a NaN, picks that NaN. When one operand is quiet and the other signaling, it picks the quiet one.
- R6: Policy code 2, when both operands are NaNs of the same kind, picks the larger significand. Words are compared with the sign bit dropped (bits 30:0, unsigned). On equal magnitudes, a wins when its raw 32-bit word is unsigned-smaller than b's, so a positive operand beats a negative one.
- R7: A selected signaling NaN is made quiet. With `sigBitOne`=0 this means setting bit 22 and keeping all other bits. With `sigBitOne`=1 the word is replaced by 0x7FBFFFFF.
- R8: With `defaultMode`=1 the result is 0x7FC00000 when `sigBitOne`=0 and 0x7FBFFFFF when `sigBitOne`=1, whatever the operands are.
- R9: `invalidFlag` is set on the edge that accepts a strobed pair in which either operand is signaling. This also applies in default-NaN mode. The flag then stays set until `flagClear` is high at a clock edge. A new set and a clear on the same edge leave the flag set.
- R10: With `REG_OUT`=1, `result` and `outValid` change on the edge after `inValid` is high. `outValid` is low on the cycles after edges with no strobe, and `result` holds its value through them. After reset, `result`, `outValid` and `invalidFlag` are all 0.
- R11: Policy code 3 behaves as code 0. When neither operand is a NaN, b is returned unchanged under every policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand pair strobe |
| opA | input | 32 | Operand a |
| opB | input | 32 | Operand b |
| policy | input | 2 | Selection policy code (0 ordered, 1 first-NaN, 2 larger-significand, 3 as 0) |
| sigBitOne | input | 1 | 1: a set bit 22 marks a signaling NaN |
| defaultMode | input | 1 | 1: always output the default NaN |
| flagClear | input | 1 | Clears the sticky invalid flag |
| outValid | output | 1 | Result valid |
| result | output | 32 | Propagated NaN word |
| invalidFlag | output | 1 | Sticky invalid-operation flag |

## Verification
Every pairing of ordinary value, quiet NaN and signaling NaN on the two operands is driven under both bit conventions, all four policy codes and both default-NaN settings. This separates the ranking of each policy and the effect of the polarity swap on classification. It also shows whether the flag and the silencing depend on the winning operand or on either operand.

Directed pairs cover several boundaries:
- infinity next to a NaN;
- 0x7FC00000 read under each convention;
- equal magnitudes with opposite signs, and strictly ordered magnitudes, for the tie-break;
- a clear coinciding with a new signaling pair;
- idle cycles where the operands change but the held result must not.

// File: rtl/nanp_pkg.sv
package nanp_pkg;
  typedef enum logic [1:0] {
    PICK_ORDERED = 2'd0,
    PICK_FIRST   = 2'd1,
    PICK_LARGER  = 2'd2,
    PICK_ALIAS   = 2'd3
  } pickPolicy_e;

  typedef struct packed {
    logic isQuiet;
    logic isSignal;
  } nanKind_t;

  typedef struct packed {
    logic capture;
    logic raiseFlag;
    logic dropFlag;
  } ctrlStrobe_t;
endpackage

// File: rtl/nanp_classify.sv
module nanp_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  input  logic                  sigBitOne,
  output nanp_pkg::nanKind_t    kind
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int QBIT   = FRAC_W - 1;

  logic expOnes, qBit, lowAny, normQuiet, normSig;

  always_comb begin
    expOnes   = &word[WORD_W-2 -: EXP_W];
    qBit      = word[QBIT];
    lowAny    = |word[QBIT-1:0];
    normQuiet = expOnes & qBit;
    normSig   = expOnes & ~qBit & lowAny;
    kind.isQuiet  = sigBitOne ? normSig : normQuiet;
    kind.isSignal = sigBitOne ? normQuiet : normSig;
  end
endmodule

// File: rtl/nanp_datapath.sv
module nanp_datapath #(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [EXP_W+FRAC_W:0]   opA,
  input  logic [EXP_W+FRAC_W:0]   opB,
  input  logic [1:0]              policy,
  input  logic                    sigBitOne,
  input  logic                    defaultMode,
  input  nanp_pkg::ctrlStrobe_t   strobe,
  output logic                    anySignal,
  output logic [EXP_W+FRAC_W:0]   result
);
  import nanp_pkg::*;

  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int QBIT   = FRAC_W - 1;
  localparam logic [WORD_W-1:0] DFLT_NORM = {1'b0, {EXP_W{1'b1}}, 1'b1, {QBIT{1'b0}}};
  localparam logic [WORD_W-1:0] DFLT_INV  = {1'b0, {EXP_W{1'b1}}, 1'b0, {QBIT{1'b1}}};
  localparam logic [WORD_W-1:0] QUIET_SET = {{(WORD_W-QBIT-1){1'b0}}, 1'b1, {QBIT{1'b0}}};

  nanKind_t kindA, kindB, chosenKind;
  logic [WORD_W-2:0] magA, magB;
  logic aLarger, aNan, bNan, pickB;
  logic [WORD_W-1:0] chosen, dfltNan, nextResult;

  nanp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classA (
    .word(opA), .sigBitOne(sigBitOne), .kind(kindA));
  nanp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classB (
    .word(opB), .sigBitOne(sigBitOne), .kind(kindB));

  always_comb begin
    magA    = opA[WORD_W-2:0];
    magB    = opB[WORD_W-2:0];
    aLarger = (magA > magB) | ((magA == magB) & (opA < opB));
    aNan    = kindA.isQuiet | kindA.isSignal;
    bNan    = kindB.isQuiet | kindB.isSignal;
    case (pickPolicy_e'(policy))
      PICK_FIRST: pickB = ~aNan;
      PICK_LARGER: begin
        if (kindA.isSignal) begin
          pickB = kindB.isSignal ? ~aLarger : kindB.isQuiet;
        end else if (kindA.isQuiet) begin
          pickB = (kindB.isQuiet & ~kindB.isSignal) ? ~aLarger : 1'b0;
        end else begin
          pickB = 1'b1;
        end
      end
      default: begin
        if (kindA.isSignal)      pickB = 1'b0;
        else if (kindB.isSignal) pickB = 1'b1;
        else                     pickB = ~kindA.isQuiet;
      end
    endcase
    chosen     = pickB ? opB : opA;
    chosenKind = pickB ? kindB : kindA;
    dfltNan    = sigBitOne ? DFLT_INV : DFLT_NORM;
    if (defaultMode)              nextResult = dfltNan;
    else if (!chosenKind.isSignal) nextResult = chosen;
    else if (sigBitOne)           nextResult = dfltNan;
    else                          nextResult = chosen | QUIET_SET;
    anySignal = kindA.isSignal | kindB.isSignal;
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [WORD_W-1:0] resultQ;
      always_ff @(posedge clk) begin
        if (!rst_n)              resultQ <= '0;
        else if (strobe.capture) resultQ <= nextResult;
      end
      assign result = resultQ;
    end else begin : g_comb
      assign result = nextResult;
    end
  endgenerate
endmodule

// File: rtl/nanp_control.sv
module nanp_control #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  inValid,
  input  logic                  flagClear,
  input  logic                  anySignal,
  output nanp_pkg::ctrlStrobe_t strobe,
  output logic                  outValid,
  output logic                  invalidFlag
);
  logic flagQ;

  always_comb begin
    strobe.capture   = inValid;
    strobe.raiseFlag = inValid & anySignal;
    strobe.dropFlag  = flagClear;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                flagQ <= 1'b0;
    else if (strobe.raiseFlag) flagQ <= 1'b1;
    else if (strobe.dropFlag)  flagQ <= 1'b0;
  end
  assign invalidFlag = flagQ;

  generate
    if (REG_OUT) begin : g_reg
      logic validQ;
      always_ff @(posedge clk) begin
        if (!rst_n) validQ <= 1'b0;
        else        validQ <= inValid;
      end
      assign outValid = validQ;
    end else begin : g_comb
      assign outValid = inValid;
    end
  endgenerate
endmodule

// File: rtl/nan_propagator.sv
module nan_propagator #(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [1:0]  policy,
  input  logic        sigBitOne,
  input  logic        defaultMode,
  input  logic        flagClear,
  output logic        outValid,
  output logic [31:0] result,
  output logic        invalidFlag
);
  nanp_pkg::ctrlStrobe_t strobe;
  logic anySignal;

  nanp_control #(.REG_OUT(REG_OUT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .flagClear(flagClear),
    .anySignal(anySignal), .strobe(strobe), .outValid(outValid),
    .invalidFlag(invalidFlag));

  nanp_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .REG_OUT(REG_OUT)) u_dp (
    .clk(clk), .rst_n(rst_n), .opA(opA), .opB(opB), .policy(policy),
    .sigBitOne(sigBitOne), .defaultMode(defaultMode), .strobe(strobe),
    .anySignal(anySignal), .result(result));
endmodule

// File: rtl/nanp_checker.sv
module nanp_checker #(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        inValid,
  input logic        sigBitOne,
  input logic        defaultMode,
  input logic        flagClear,
  input logic        outValid,
  input logic [31:0] result,
  input logic        invalidFlag
);
  localparam int QBIT = FRAC_W - 1;
  localparam logic [31:0] DN_NORM = {1'b0, {EXP_W{1'b1}}, 1'b1, {QBIT{1'b0}}};
  localparam logic [31:0] DN_INV  = {1'b0, {EXP_W{1'b1}}, 1'b0, {QBIT{1'b1}}};

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (invalidFlag && !flagClear) |=> invalidFlag);
  // R9
  flag_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(invalidFlag) |-> $past(inValid));

  generate
    if (REG_OUT) begin : g_seq
      // R10
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inValid |=> outValid);
      // R10
      valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inValid |=> !outValid);
      // R10
      hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inValid |=> $stable(result));
      // R8
      default_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inValid && defaultMode) |=>
          (result == ($past(sigBitOne) ? DN_INV : DN_NORM)));
    end
  endgenerate
endmodule

bind nan_propagator nanp_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .sigBitOne(sigBitOne),
  .defaultMode(defaultMode), .flagClear(flagClear), .outValid(outValid),
  .result(result), .invalidFlag(invalidFlag));

// File: tb/test_nan_propagator.sv
module test_nan_propagator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [1:0] policy = '0;
  logic sigBitOne = 1'b0, defaultMode = 1'b0, flagClear = 1'b0;
  logic outValid, invalidFlag;
  logic [31:0] result;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;
  bit expFlag = 0;
  logic [31:0] lastRes = '0;

  nan_propagator i_nan_propagator (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opA(opA), .opB(opB),
    .policy(policy), .sigBitOne(sigBitOne), .defaultMode(defaultMode),
    .flagClear(flagClear), .outValid(outValid), .result(result),
    .invalidFlag(invalidFlag));

  always #2 clk = ~clk;

  function automatic bit isNan(logic [31:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] != 23'd0);
  endfunction

  function automatic bit quietOf(logic [31:0] w, bit conv);
    if (!isNan(w)) return 1'b0;
    return conv ? (w[22] == 1'b0) : (w[22] == 1'b1);
  endfunction

  function automatic bit sigOf(logic [31:0] w, bit conv);
    return isNan(w) && !quietOf(w, conv);
  endfunction

  function automatic logic [31:0] refModel(logic [31:0] a, logic [31:0] b,
                                           int pol, bit conv, bit dm);
    logic [31:0] dn, sel;
    bit pickA, aBig;
    int unsigned ma, mb;
    dn = conv ? 32'h7FBFFFFF : 32'h7FC00000;
    if (dm) return dn;
    ma = a << 1;
    mb = b << 1;
    if (ma != mb) aBig = (ma > mb);
    else aBig = (a < b);
    if (pol == 1) pickA = isNan(a);
    else if (pol == 2) begin
      if (isNan(a) && isNan(b))
        pickA = (quietOf(a, conv) != quietOf(b, conv)) ? quietOf(a, conv) : aBig;
      else
        pickA = isNan(a);
    end else
      pickA = sigOf(a, conv) || (!sigOf(b, conv) && quietOf(a, conv));
    sel = pickA ? a : b;
    if (!sigOf(sel, conv)) return sel;
    return conv ? dn : (sel | 32'h00400000);
  endfunction

  function automatic logic [31:0] operand(int kind, bit conv, int v);
    if (kind == 0) return v ? 32'hC0490FDB : 32'h3F800000;
    if ((kind == 1) != conv) return v ? 32'hFFC01234 : 32'h7FC00001;
    return v ? 32'hFF800ABC : 32'h7F812345;
  endfunction

  function automatic string polTag(int pol);
    case (pol)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  // Called at a negedge: drive a strobed pair, step to the next negedge, compare.
  task automatic applyVec(string tag, logic [31:0] a, logic [31:0] b, int pol,
                          bit conv, bit dm, bit clr);
    logic [31:0] er;
    opA = a; opB = b; policy = pol[1:0]; sigBitOne = conv; defaultMode = dm;
    flagClear = clr; inValid = 1'b1;
    er = refModel(a, b, pol, conv, dm);
    if (sigOf(a, conv) || sigOf(b, conv)) expFlag = 1'b1;
    else if (clr) expFlag = 1'b0;
    @(negedge clk);
    check(tag, "result", result, er);
    check(tag, "outValid", {31'd0, outValid}, 32'd1);
    check(tag, "invalidFlag", {31'd0, invalidFlag}, {31'd0, expFlag});
    lastRes = er;
  endtask

  task automatic idle(string tag, bit clr);
    inValid = 1'b0; flagClear = clr;
    opA = 32'hFF800001; opB = 32'h7F800001; defaultMode = ~defaultMode;
    if (clr) expFlag = 1'b0;
    @(negedge clk);
    check(tag, "held result", result, lastRes);
    check(tag, "outValid", {31'd0, outValid}, 32'd0);
    check(tag, "invalidFlag", {31'd0, invalidFlag}, {31'd0, expFlag});
    flagClear = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finishRun();
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "reset result", result, 32'd0);
    check("R10", "reset outValid", {31'd0, outValid}, 32'd0);
    check("R10", "reset flag", {31'd0, invalidFlag}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    cnt = 0;
    for (int conv = 0; conv < 2; conv++)
      for (int pol = 0; pol < 4; pol++)
        for (int dm = 0; dm < 2; dm++)
          for (int ka = 0; ka < 3; ka++)
            for (int kb = 0; kb < 3; kb++)
              for (int v = 0; v < 2; v++) begin
                applyVec(dm ? "R8" : polTag(pol), operand(ka, conv[0], v),
                         operand(kb, conv[0], 1 - v), pol, conv[0], dm[0], (cnt % 3) == 0);
                cnt++;
                if ((cnt % 17) == 0) idle("R10", 1'b0);
              end

    // R1 infinity is not a NaN
    applyVec("R1", 32'h7F800000, 32'h3F800000, 1, 0, 0, 0);
    applyVec("R1", 32'h7F800000, 32'h7FC00000, 1, 0, 0, 0);
    applyVec("R1", 32'h7FC00000, 32'hFF800001, 0, 0, 0, 0);
    // R2 polarity swap
    applyVec("R2", 32'h7FC00000, 32'h7F800001, 0, 1, 0, 0);
    applyVec("R2", 32'h7F800001, 32'h3F800000, 1, 1, 0, 1);
    // R6 magnitude and sign tie-break
    applyVec("R6", 32'h7FC00005, 32'h7FC00003, 2, 0, 0, 0);
    applyVec("R6", 32'h7FC00003, 32'h7FC00005, 2, 0, 0, 0);
    applyVec("R6", 32'hFFC00003, 32'h7FC00003, 2, 0, 0, 0);
    applyVec("R6", 32'h7FC00003, 32'hFFC00003, 2, 0, 0, 0);
    applyVec("R6", 32'h7F800009, 32'h7F800002, 2, 0, 0, 0);
    applyVec("R6", 32'h7F800002, 32'hFF800009, 2, 1, 0, 0);
    // R7 silencing in both conventions
    applyVec("R7", 32'hFF812345, 32'h3F800000, 1, 0, 0, 0);
    applyVec("R7", 32'hFFC12345, 32'h3F800000, 1, 1, 0, 0);
    // R8 default NaN, quiet operands leave a cleared flag clear
    idle("R9", 1'b1);
    applyVec("R8", 32'h7FC00001, 32'h3F800000, 0, 0, 1, 0);
    applyVec("R8", 32'h7F800001, 32'h3F800000, 0, 1, 1, 0);
    // R9 set beats clear on the same edge; clear afterwards
    applyVec("R9", 32'h7F800001, 32'h3F800000, 2, 0, 1, 1);
    idle("R9", 1'b0);
    idle("R9", 1'b1);
    // R11 neither operand is a NaN
    applyVec("R11", 32'h40000000, 32'hC0000000, 2, 0, 0, 0);
    applyVec("R11", 32'h40000000, 32'hC0000000, 3, 1, 0, 0);
    idle("R10", 1'b0);
    finishRun();
  end
endmodule